// File: doc/BRIEF.md
# Configuration Base Address Register with Size Discovery

This block is one relocatable address window of a device's configuration header. Host software reads and writes configuration dwords through a simple port: one dword index, write data and a write strobe, with read data returned combinationally for the index presented. Through that port it reaches a command register holding a memory-space enable and an I/O-space enable. It also reaches the base register itself, which occupies one dword slot. When the window is a 64-bit memory window it occupies two adjacent slots, the lower half first.

The window size is a power of two fixed by a parameter. Address bits below that size are not stored and read back as zero. Writing all ones and reading back therefore yields the size mask, and the low attribute field reports the space, width and prefetch property and cannot be changed. A host decode port takes an address and a space indicator per request. One cycle later it reports a hit when the matching enable is set, the space matches and the masked address equals the stored base. Reprogramming the base moves the window from the next request onward.

Top module: `bar_probe_unit`

## Requirements
- R1: After reset the command register reads 0, the base reads back only its attribute bits, the upper half (64-bit window) reads 0, and no hit is reported.
- R2: The attribute bits never change on a write. A memory window reads bit 0 = 0, bits 2:1 = 10 when 64-bit and 00 when 32-bit, and bit 3 = the prefetch parameter. An I/O window reads bit 0 = 1 and bit 1 = 0.
- R3: Base bits below log2 of the window size, other than the attribute bits, read as 0. After an all-ones write, a 2 KB 64-bit prefetchable window reads 0xFFFFF80C, and a 32-byte I/O window reads 0xFFFFFFE1.
- R4: In a 64-bit window the upper dword, at the slot after the lower one, stores all 32 bits; an all-ones write reads back 0xFFFFFFFF.
- R5: The command register is at dword index 1. Bit 0 is the I/O-space enable and bit 1 is the memory-space enable. All other bits read 0.
- R6: A request asserts the hit output in the following cycle when the enable for the window's space is set, the request's space indicator (1 = I/O) matches, and the address masked to the window equals the base. This covers every byte from the base to base + size - 1.
- R7: With the matching enable cleared, no request produces a hit.
- R8: A write to the base takes effect for the next request. After an all-ones probe write the old base no longer hits, and after a new base is written the new base hits while the old one misses.
- R9: A request of the wrong space never hits. A 32-bit or I/O window never hits an address whose upper 32 bits are nonzero.
- R10: Dword indices other than the command and base slots read 0, and writes to them change neither those readbacks nor the base.
- R11: The address just below the base and the address base + size miss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration dword write strobe |
| cfg_dw | input | 6 | Configuration dword index (byte offset / 4) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_dw |
| host_req | input | 1 | Host decode request valid |
| host_io | input | 1 | Request space: 1 = I/O, 0 = memory |
| host_addr | input | 64 | Request address |
| host_hit | output | 1 | Request fell in the window, one cycle after the request |

## Verification
The bench aims at the size probe. A design that stored the low address bits would read back 0xFFFFFFFF instead of the mask. One that let writes reach the attribute field would report the wrong space or width. It probes both edges of the window and the byte just outside each edge, which an off-by-one mask or a compare on the unmasked address would get wrong. It checks that an upper-half mismatch misses and that the old base stops hitting the moment it is overwritten. It also checks the space indicator and each enable independently, since a design that swapped the command bits or ignored the request's space would hit on the wrong kind of access.

// File: rtl/bar_pkg.sv
package bar_pkg;

    // Command register fields that this block keeps
    typedef struct packed {
        logic mem_en;
        logic io_en;
    } cmd_t;

    // One host decode request
    typedef struct packed {
        logic        valid;
        logic        is_io;
        logic [63:0] addr;
    } host_req_t;

    localparam int unsigned CMD_DW       = 1;
    localparam int unsigned BAR_FIRST_DW = 4;
    localparam int unsigned MEM_MIN_LOG2 = 4;
    localparam int unsigned IO_MIN_LOG2  = 2;

    // Address compare mask; a narrow window also pins the upper half to zero
    function automatic logic [63:0] win_mask(input int unsigned log2, input logic wide);
        logic [63:0] m;
        m = {64{1'b1}} << log2;
        if (!wide) m[63:32] = 32'hFFFF_FFFF;
        return m;
    endfunction

    // Hard-wired attribute field of the lower dword
    function automatic logic [31:0] attr_bits(input logic is_io, input logic wide, input logic pf);
        logic [31:0] a;
        a = '0;
        if (is_io) begin
            a[0] = 1'b1;
        end else begin
            a[2] = wide;
            a[3] = pf;
        end
        return a;
    endfunction

endpackage

// File: rtl/bar_cfg_regs.sv
module bar_cfg_regs
    import bar_pkg::*;
#(
    parameter logic        WIDE   = 1'b1,
    parameter logic [63:0] MASK   = 64'hFFFF_FFFF_FFFF_F800,
    parameter logic [31:0] ATTR   = 32'h0000_000C,
    parameter logic [5:0]  BAR_DW = 6'd4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic [5:0]  cfg_dw,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output cmd_t        cmd,
    output logic [63:0] base
);

    localparam logic [5:0] CMD_IDX = 6'(CMD_DW);
    localparam logic [5:0] HI_DW   = BAR_DW + 6'd1;

    cmd_t        cmd_q;
    logic [31:0] lo_q;
    logic [31:0] hi_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            lo_q  <= '0;
        end else if (cfg_wr) begin
            if (cfg_dw == CMD_IDX) begin
                cmd_q.io_en  <= cfg_wdata[0];
                cmd_q.mem_en <= cfg_wdata[1];
            end
            if (cfg_dw == BAR_DW) lo_q <= cfg_wdata & MASK[31:0];
        end
    end

    generate
        if (WIDE) begin : g_upper
            logic [31:0] hi_q;
            always_ff @(posedge clk) begin
                if (rst)                            hi_q <= '0;
                else if (cfg_wr && cfg_dw == HI_DW) hi_q <= cfg_wdata & MASK[63:32];
            end
            assign hi_val = hi_q;
        end else begin : g_narrow
            assign hi_val = '0;
        end
    endgenerate

    always_comb begin
        cfg_rdata = '0;
        if (cfg_dw == CMD_IDX)             cfg_rdata = {30'd0, cmd_q.mem_en, cmd_q.io_en};
        else if (cfg_dw == BAR_DW)         cfg_rdata = lo_q | ATTR;
        else if (WIDE && cfg_dw == HI_DW)  cfg_rdata = hi_val;
    end

    assign cmd  = cmd_q;
    assign base = {hi_val, lo_q};

endmodule

// File: rtl/bar_decode.sv
module bar_decode
    import bar_pkg::*;
#(
    parameter logic        IS_IO = 1'b0,
    parameter logic [63:0] MASK  = 64'hFFFF_FFFF_FFFF_F800
) (
    input  logic        clk,
    input  logic        rst,
    input  host_req_t   req,
    input  logic        enable,
    input  logic [63:0] base,
    output logic        hit
);

    logic hit_q;
    logic match;

    assign match = req.valid && enable && (req.is_io == IS_IO)
                   && ((req.addr & MASK) == base);

    always_ff @(posedge clk) begin
        if (rst) hit_q <= 1'b0;
        else     hit_q <= match;
    end

    assign hit = hit_q;

endmodule

// File: rtl/bar_probe_unit.sv
module bar_probe_unit
    import bar_pkg::*;
#(
    parameter int unsigned WIN_LOG2 = 11,
    parameter bit          IS_IO    = 1'b0,
    parameter bit          IS_64    = 1'b1,
    parameter bit          PREFETCH = 1'b1,
    parameter int unsigned BAR_SLOT = 0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic [5:0]  cfg_dw,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        host_req,
    input  logic        host_io,
    input  logic [63:0] host_addr,
    output logic        host_hit
);

    localparam int unsigned MIN_LOG2  = IS_IO ? IO_MIN_LOG2 : MEM_MIN_LOG2;
    localparam int unsigned EFF_LOG2  = (WIN_LOG2 < MIN_LOG2) ? MIN_LOG2 : WIN_LOG2;
    localparam logic        WIDE      = IS_64 && !IS_IO;
    localparam logic [63:0] MASK      = win_mask(EFF_LOG2, WIDE);
    localparam logic [31:0] ATTR      = attr_bits(IS_IO, WIDE, PREFETCH);
    localparam logic [5:0]  BAR_DW    = 6'(BAR_FIRST_DW + BAR_SLOT);
    localparam logic [31:0] ZERO_MASK = ~MASK[31:0] & ~ATTR & (IS_IO ? 32'hFFFF_FFFC : 32'hFFFF_FFF0);

    cmd_t        cmd;
    logic [63:0] base;
    logic        space_en;
    host_req_t   req;

    bar_cfg_regs #(
        .WIDE   (WIDE),
        .MASK   (MASK),
        .ATTR   (ATTR),
        .BAR_DW (BAR_DW)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_dw    (cfg_dw),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cmd       (cmd),
        .base      (base)
    );

    assign space_en  = IS_IO ? cmd.io_en : cmd.mem_en;
    assign req.valid = host_req;
    assign req.is_io = host_io;
    assign req.addr  = host_addr;

    bar_decode #(
        .IS_IO (IS_IO),
        .MASK  (MASK)
    ) u_dec (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .enable (space_en),
        .base   (base),
        .hit    (host_hit)
    );

endmodule

// File: rtl/bar_probe_chk.sv
module bar_probe_chk #(
    parameter bit          IS_IO     = 1'b0,
    parameter logic [5:0]  BAR_DW    = 6'd4,
    parameter logic [31:0] ATTR      = 32'h0000_000C,
    parameter logic [31:0] ZERO_MASK = 32'h0000_07F0
) (
    input logic        clk,
    input logic        rst,
    input logic        cfg_wr,
    input logic [5:0]  cfg_dw,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic        host_req,
    input logic        host_io,
    input logic        host_hit,
    input logic        space_en
);

    localparam logic [31:0] ATTR_KEEP = IS_IO ? 32'h3 : 32'hF;

    // R1
    reset_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !host_hit);

    // R7
    hit_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        host_hit |-> $past(host_req && space_en && (host_io == IS_IO)));

    // R2
    attr_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_dw == BAR_DW) |-> ((cfg_rdata & ATTR_KEEP) == ATTR));

    // R3
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_dw == BAR_DW) |-> ((cfg_rdata & ZERO_MASK) == 32'd0));

    // R5
    cmd_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_dw == 6'd1) |-> (cfg_rdata[31:2] == 30'd0));

    // R5
    cmd_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_dw == 6'd1) |=> (space_en == $past(IS_IO ? cfg_wdata[0] : cfg_wdata[1])));

endmodule

bind bar_probe_unit bar_probe_chk #(
    .IS_IO     (IS_IO),
    .BAR_DW    (BAR_DW),
    .ATTR      (ATTR),
    .ZERO_MASK (ZERO_MASK)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_dw    (cfg_dw),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .host_req  (host_req),
    .host_io   (host_io),
    .host_hit  (host_hit),
    .space_en  (space_en)
);

// File: tb/test_bar_probe_unit.sv
`timescale 1ns/1ps
module test_bar_probe_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_dw = '0;
    logic [31:0] cfg_wdata = '0;
    logic        host_req = 1'b0;
    logic        host_io = 1'b0;
    logic [63:0] host_addr = '0;
    logic [31:0] rdata_m, rdata_i;
    logic        hit_m, hit_i;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    // 2 KB, 64-bit, prefetchable memory window at dwords 4/5
    bar_probe_unit #(.WIN_LOG2(11), .IS_IO(1'b0), .IS_64(1'b1), .PREFETCH(1'b1), .BAR_SLOT(0)) i_bar_probe_unit (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rdata_m), .host_req(host_req), .host_io(host_io), .host_addr(host_addr),
        .host_hit(hit_m));

    // 32-byte I/O window at dword 6
    bar_probe_unit #(.WIN_LOG2(5), .IS_IO(1'b1), .IS_64(1'b0), .PREFETCH(1'b0), .BAR_SLOT(2)) i_bar_probe_unit_io (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rdata_i), .host_req(host_req), .host_io(host_io), .host_addr(host_addr),
        .host_hit(hit_i));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [5:0] dw, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_dw = dw; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic [5:0] dw, input bit io_inst, output logic [31:0] d);
        @(negedge clk);
        cfg_dw = dw;
        #1;
        d = io_inst ? rdata_i : rdata_m;
    endtask

    task automatic lookup(input logic [63:0] a, input logic io, output logic hm, output logic hi);
        @(negedge clk);
        host_req = 1'b1; host_addr = a; host_io = io;
        @(negedge clk);
        host_req = 1'b0;
        hm = hit_m; hi = hit_i;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        logic hm, hi;
        cfg_read(6'd4, 0, d); chk("R1 mem base after reset", d, 32'h0000_000C);
        cfg_read(6'd5, 0, d); chk("R1 upper after reset", d, 0);
        cfg_read(6'd1, 0, d); chk("R1 cmd after reset", d, 0);
        cfg_read(6'd6, 1, d); chk("R1 io base after reset", d, 32'h0000_0001);
        lookup(64'h0, 1'b0, hm, hi); chk("R1 no hit after reset", hm, 0);
    endtask

    task automatic t_probe();
        logic [31:0] d;
        cfg_write(6'd4, 32'hFFFF_FFFF);
        cfg_read(6'd4, 0, d); chk("R3 mem size mask", d, 32'hFFFF_F80C);
        chk("R2 mem attr nibble", d[3:0], 4'hC);
        cfg_write(6'd5, 32'hFFFF_FFFF);
        cfg_read(6'd5, 0, d); chk("R4 upper all ones", d, 32'hFFFF_FFFF);
        cfg_write(6'd6, 32'hFFFF_FFFF);
        cfg_read(6'd6, 1, d); chk("R3 io size mask", d, 32'hFFFF_FFE1);
        cfg_write(6'd4, 32'h0000_0000);
        cfg_read(6'd4, 0, d); chk("R2 attr survives zero write", d, 32'h0000_000C);
    endtask

    task automatic t_cmd();
        logic [31:0] d;
        cfg_write(6'd1, 32'hFFFF_FFFF);
        cfg_read(6'd1, 0, d); chk("R5 cmd keeps two bits", d, 32'h3);
        cfg_write(6'd1, 32'h0000_0002);
        cfg_read(6'd1, 1, d); chk("R5 cmd mem only", d, 32'h2);
    endtask

    task automatic t_decode();
        logic [31:0] d;
        logic hm, hi;
        cfg_write(6'd4, 32'hF1BF_F800);
        cfg_write(6'd5, 32'h0000_0001);
        cfg_write(6'd6, 32'h0000_C023);
        cfg_read(6'd4, 0, d); chk("R2 base with attr", d, 32'hF1BF_F80C);
        cfg_read(6'd6, 1, d); chk("R2 io base with attr", d, 32'h0000_C021);
        lookup(64'h1_F1BF_F800, 1'b0, hm, hi); chk("R6 hit at base", hm, 1);
        lookup(64'h1_F1BF_FFFF, 1'b0, hm, hi); chk("R6 hit at last byte", hm, 1);
        lookup(64'h1_F1BF_F7FF, 1'b0, hm, hi); chk("R11 miss below base", hm, 0);
        lookup(64'h1_F1C0_0000, 1'b0, hm, hi); chk("R11 miss at base+size", hm, 0);
        lookup(64'h0_F1BF_F800, 1'b0, hm, hi); chk("R6 miss upper differs", hm, 0);
        lookup(64'h1_F1BF_F800, 1'b1, hm, hi); chk("R9 mem window ignores io", hm, 0);
        lookup(64'h0_0000_C020, 1'b1, hm, hi); chk("R7 io disabled", hi, 0);
    endtask

    task automatic t_io_space();
        logic hm, hi;
        cfg_write(6'd1, 32'h0000_0003);
        lookup(64'h0_0000_C03F, 1'b1, hm, hi); chk("R6 io hit last byte", hi, 1);
        lookup(64'h0_0000_C040, 1'b1, hm, hi); chk("R11 io miss at base+size", hi, 0);
        lookup(64'h0_0000_C020, 1'b0, hm, hi); chk("R9 io window ignores mem", hi, 0);
        lookup(64'h1_0000_C020, 1'b1, hm, hi); chk("R9 io upper nonzero", hi, 0);
    endtask

    task automatic t_disable();
        logic hm, hi;
        cfg_write(6'd1, 32'h0000_0001);
        lookup(64'h1_F1BF_F800, 1'b0, hm, hi); chk("R7 mem disabled", hm, 0);
        lookup(64'h0_0000_C020, 1'b1, hm, hi); chk("R5 io enable bit0", hi, 1);
    endtask

    task automatic t_relocate();
        logic hm, hi;
        cfg_write(6'd1, 32'h0000_0003);
        lookup(64'h1_F1BF_F800, 1'b0, hm, hi); chk("R8 hit before probe", hm, 1);
        cfg_write(6'd4, 32'hFFFF_FFFF);
        lookup(64'h1_F1BF_F800, 1'b0, hm, hi); chk("R8 old base miss during probe", hm, 0);
        cfg_write(6'd4, 32'hF1BF_F000);
        lookup(64'h1_F1BF_F000, 1'b0, hm, hi); chk("R8 new base hits", hm, 1);
        lookup(64'h1_F1BF_F800, 1'b0, hm, hi); chk("R8 old base misses", hm, 0);
    endtask

    task automatic t_other();
        logic [31:0] d;
        cfg_write(6'd2, 32'h1234_5678);
        cfg_write(6'd63, 32'hFFFF_FFFF);
        cfg_read(6'd2, 0, d);  chk("R10 other index reads 0", d, 0);
        cfg_read(6'd63, 0, d); chk("R10 last index reads 0", d, 0);
        cfg_read(6'd6, 0, d);  chk("R10 mem unit ignores io slot", d, 0);
        cfg_read(6'd4, 1, d);  chk("R10 io unit ignores mem slot", d, 0);
        cfg_read(6'd4, 0, d);  chk("R10 base unchanged", d, 32'hF1BF_F00C);
        cfg_read(6'd6, 1, d);  chk("R10 io base unchanged", d, 32'h0000_C021);
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_probe();
        t_cmd();
        t_decode();
        t_io_space();
        t_disable();
        t_relocate();
        t_other();
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

endmodule